// File: doc/BRIEF.md
# Cascaded 16:1 Word Serializer

This block turns 16-bit parallel words into a one-bit serial stream. It works from a single fast clock. A divide-by-8 strobe, `div_stb`, marks the edges of the slow parallel clock. Each word is split into two 8-bit halves. A half-select toggle, clocked by the strobe, feeds the halves one after the other into an 8:1 parallel-to-serial core. The select changes on every strobe, so a complete word is taken once every two strobe periods (16 fast cycles).

The core has three stages:

- **Input register.** It has no enable and captures the selected half on every strobe.
- **Holding register.** It takes the input register's contents one cycle after the strobe. This lets the next half wait while the current half is still shifting.
- **Shift register.** It reloads from the holding register only after all 8 bits have been shifted out.

The output enable acts only on the final output flop. While the enable is low the serial bit holds its value, but loading, transfer and shifting carry on.

The input side follows a ready-only stream rule. `in_ready` pulses on the strobe cycle in which the half-select is at its low state, and `in_word` is taken on that edge. The block cannot apply back-pressure, and the source cannot stall the block. The source must therefore present a valid word in every cycle where `in_ready` is high. Words presented in any other cycle are ignored.

Top module: `word_serializer_16`

## Requirements
- R1: A synchronous active-high `rst` clears the half-select to the low state, clears every data register and drives `ser_out` to 0. While reset is held, `in_ready` is 0 when `div_stb` is 0.
- R2: The half-select toggles on every `div_stb` cycle. `in_ready` is high exactly when `div_stb` is high and the half-select is in its low state, so it rises on every second strobe.
- R3: With `oe` high, bit n (0 to 15) of a word taken at rising edge E appears on `ser_out` right after edge E+9+n. Bits 7:0 go first and bits 15:8 second, each half LSB first.
- R4: The input register captures the selected half on every strobe, whatever the value of `oe`.
- R5: Words taken on consecutive `in_ready` pulses form a gapless serial stream. The next half is loaded while the current half is still shifting.
- R6: While `oe` is low, `ser_out` keeps the value it had after the last edge at which `oe` was high.
- R7: Shifting continues while `oe` is low. Once `oe` returns high, `ser_out` shows the bit that the R3 schedule assigns to that edge, with no delay and no reordering.
- R8: `in_word` values in cycles where `in_ready` is low have no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-bit clock |
| rst | input | 1 | Synchronous active-high reset |
| div_stb | input | 1 | Slow-clock strobe, high one cycle in every 8 |
| in_word | input | 16 | Parallel word, taken when `in_ready` is high |
| in_ready | output | 1 | Word-accept pulse (strobe with half-select low) |
| oe | input | 1 | Output enable for the final output flop only |
| ser_out | output | 1 | Serial data bit |

## Verification
The bench keeps its own model of the half-select. When a word is taken at edge E, the model schedules bit n for the edge E+9+n. After every rising edge the model updates an expected output bit, loading the scheduled bit when `oe` was high and holding the previous value when it was low. The bench compares `ser_out` with that bit at the following falling edge. `in_ready` is combinational, so it is checked one time step after the inputs are driven on the falling edge. Random words are driven in non-accept cycles and `oe` is toggled at random, so any bit that is dropped, delayed or reordered shows up as a mismatch in the exact cycle the schedule predicts.

// File: rtl/wser_pkg.sv
package wser_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic half_e half_flip(half_e h);
    return (h == HALF_LO) ? HALF_HI : HALF_LO;
  endfunction
endpackage

// File: rtl/wser_half_mux.sv
module wser_half_mux
  import wser_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [WORD_W-1:0] word,
  output logic              take,
  output logic [HALF_W-1:0] in_q
);
  half_e             half;
  logic [HALF_W-1:0] upper_keep;
  logic [HALF_W-1:0] sel_half;

  assign take     = stb && (half == HALF_LO);
  assign sel_half = (half == HALF_LO) ? word[HALF_W-1:0] : upper_keep;

  // Input register: no enable of its own, it loads on every strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      half       <= HALF_LO;
      upper_keep <= '0;
      in_q       <= '0;
    end else if (stb) begin
      half <= half_flip(half);
      in_q <= sel_half;
      if (half == HALF_LO) upper_keep <= word[WORD_W-1:HALF_W];
    end
  end

  // R1
  a_r1_half_reset: assert property (@(posedge clk) rst |=> (half == HALF_LO));
  a_r2_half_toggles: assert property (@(posedge clk) disable iff (rst)
    stb |=> (half != $past(half)));
  a_r2_half_steady: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(half));
  a_r8_upper_quiet: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(upper_keep));
endmodule

// File: rtl/wser_p2s.sv
module wser_p2s #(
  parameter int HALF_W = 8,
  localparam int CNT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1,
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [HALF_W-1:0] in_q,
  output logic              sbit
);
  logic              stb_d;
  logic [HALF_W-1:0] hold;
  logic [HALF_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic              width_done;

  assign width_done = (cnt == LAST);
  assign sbit       = sreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d <= 1'b0;
      hold  <= '0;
      sreg  <= '0;
      cnt   <= '0;
    end else begin
      stb_d <= stb;
      if (stb_d) hold <= in_q;
      if (width_done) sreg <= hold;
      else            sreg <= sreg >> 1;
      if (stb || width_done) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  a_r5_transfer_at_width: assert property (@(posedge clk) disable iff (rst)
    width_done |=> (sreg == $past(hold)));
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    !stb_d |=> $stable(hold));
endmodule

// File: rtl/wser_out_stage.sv
module wser_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic oe,
  input  logic sbit,
  output logic ser_q
);
  always_ff @(posedge clk) begin
    if (rst)     ser_q <= 1'b0;
    else if (oe) ser_q <= sbit;
  end

  a_r1_out_reset: assert property (@(posedge clk) rst |=> (ser_q == 1'b0));
  a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
    !oe |=> $stable(ser_q));
  a_r7_follow: assert property (@(posedge clk) disable iff (rst)
    oe |=> (ser_q == $past(sbit)));
endmodule

// File: rtl/word_serializer_16.sv
module word_serializer_16 #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_stb,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              oe,
  output logic              ser_out
);
  logic [HALF_W-1:0] in_q;
  logic              sbit;

  wser_half_mux #(.HALF_W(HALF_W)) u_mux (
    .clk(clk), .rst(rst), .stb(div_stb), .word(in_word),
    .take(in_ready), .in_q(in_q)
  );

  wser_p2s #(.HALF_W(HALF_W)) u_p2s (
    .clk(clk), .rst(rst), .stb(div_stb), .in_q(in_q), .sbit(sbit)
  );

  wser_out_stage u_out (
    .clk(clk), .rst(rst), .oe(oe), .sbit(sbit), .ser_q(ser_out)
  );

  a_r2_ready_spacing: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);
endmodule

// File: tb/word_serializer_16_tb.sv
module word_serializer_16_tb;
  localparam int NCYC = 2400;
  localparam int LAT  = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        div_stb = 1'b0;
  logic        oe = 1'b1;
  logic [15:0] in_word = '0;
  logic        in_ready;
  logic        ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit sched [NCYC+40];
  bit out_m = 1'b0;
  bit half_m = 1'b0;
  int widx = 0;

  always #5 clk = ~clk;

  word_serializer_16 u_dut (
    .clk(clk), .rst(rst), .div_stb(div_stb), .in_word(in_word),
    .in_ready(in_ready), .oe(oe), .ser_out(ser_out)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ready_model(bit s, bit h);
    return s && !h;
  endfunction

  function automatic logic [15:0] pick_word(int idx);
    case (idx)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8001;
      3: return 16'hAAAA;
      4: return 16'h00FF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic bit oe_pattern(int p);
    if (p >= 800 && p < 1000) return bit'($urandom % 2);
    if (p >= 1500 && p < 1540) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCYC + 40; i++) sched[i] = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ser_out == 1'b0, "R1", int'(ser_out), 0);
    chk(in_ready == 1'b0, "R1", int'(in_ready), 0);
    rst = 1'b0;
    for (int p = 0; p < NCYC; p++) begin
      bit s;
      bit o;
      bit r;
      logic [15:0] w;
      s = (p % 8 == 0);
      o = oe_pattern(p);
      r = ready_model(s, half_m);
      if (r) begin
        w = pick_word(widx);
        widx++;
      end else begin
        // R8: non-accept cycles carry noise that must be ignored
        w = 16'($urandom);
      end
      div_stb = s;
      oe = o;
      in_word = w;
      #1;
      chk(in_ready == r, "R2", int'(in_ready), int'(r));
      @(posedge clk);
      if (s) begin
        if (!half_m) begin
          for (int n = 0; n < 16; n++) sched[p + LAT + n] = w[n];
        end
        half_m = !half_m;
      end
      if (o) out_m = sched[p];
      @(negedge clk);
      if (!o)
        chk(ser_out == out_m, "R6", int'(ser_out), int'(out_m));
      else if (p < 800)
        chk(ser_out == out_m, "R3 R5 R8", int'(ser_out), int'(out_m));
      else
        chk(ser_out == out_m, "R4 R7", int'(ser_out), int'(out_m));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule